// File: doc/BRIEF.md
# SCSI Initiator Register Front End

This block is the byte-wide host register file of a simple SCSI initiator controller. A host processor reads and writes sixteen byte locations through a single-cycle strobe interface. The block keeps the status, interrupt, sequence-step, flag and configuration registers, and it drives one level-sensitive interrupt line back to the host. Several offsets hold two different registers: one seen by reads and one taken by writes.

A write to the command location is decoded as a DMA-mode bit (bit 7) plus a 7-bit opcode. Housekeeping opcodes (no-op, flush, software reset, bus reset, message accept, pad, enable selection) are carried out inside the block by updating the status, interrupt and sequence registers. Selection and transfer opcodes are not executed here. Instead the block sends a one-cycle start pulse, with the opcode and DMA bit, to a phase engine outside the block. That engine later writes its results back through a load port and can request an interrupt with a strobe.

Reading the interrupt register has side effects. It returns the current value and then clears the register, clears terminal count, sets the sequence step to 4 and drops the interrupt line. An opcode the block does not recognise leaves all state unchanged and sets a sticky flag on a debug output.

Top module: `scsi_regfront`

## Requirements
- R1: After hardware reset, every read location returns 0x00 except offset 8, which returns 0x07, and offset 14, which returns 0x04. After reset, `irq_o`, `go_o` and `illegal_o` are all low.
- R2: Status bit 7 (interrupt pending) and `irq_o` always agree. A raise sets both. A raise while the bit is already set changes nothing.
- R3: A read at offset 5 returns the interrupt register value held before the read. After that cycle the interrupt register is 0x00, status bit 4 (terminal count) is clear, the sequence step (offset 6) is 0x04 and `irq_o` is low. Status bits [2:0] (phase) are not changed.
- R4: Opcode 0x01 (flush) sets the interrupt register to 0x08 (function complete), clears the sequence step and the flags register (offset 7), and does not raise.
- R5: Opcode 0x18 (pad) sets status bits [6:0] to 0x10, leaves status bit 7 unchanged, sets the interrupt register to 0x08 and clears the sequence step.
- R6: Opcode 0x03 (bus reset) sets the interrupt register to 0x80. It raises the interrupt only when bit 6 of the last value written at offset 8 is 0.
- R7: Opcode 0x12 (message accept) sets the interrupt register to 0x20, clears the sequence step and flags, and raises. Opcode 0x44 (enable selection) clears the interrupt register. Opcodes 0x00 and 0x1a change nothing.
- R8: Opcode 0x02 (software reset) restores the full R1 reset state, including `irq_o` low and `illegal_o` low.
- R9: Opcodes 0x10, 0x11, 0x41, 0x42 and 0x43 give `go_o` high for exactly the cycle after the command write. In that cycle `go_op_o` carries the opcode and `go_dma_o` carries bit 7 of the command byte. Status, interrupt and sequence are not changed.
- R10: A command byte with bit 7 set copies the values last written at offsets 0 and 1 into the values read back at offsets 0 and 1. A command without bit 7 does not copy them. A write at offset 0 or 1 clears status bit 4.
- R11: Any opcode not listed in R4 to R9 sets `illegal_o`, which stays set until reset. Such an opcode changes no other state, and the value read back at offset 3 is not updated.
- R12: Writes at offsets 2, 4, 5, 6, 7, 9 and 10 change no value seen by reads. A write at offset 8 or at offsets 11 to 15 can be read back at the same offset.
- R13: `eng_ld` loads status bits [6:0], the interrupt register and the sequence step from the engine inputs, and `eng_raise` raises the interrupt. Both take priority over the side effects of a host read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| bus_rd | input | 1 | Host read strobe, one cycle |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt to the host |
| go_o | output | 1 | Start pulse to the phase engine |
| go_op_o | output | 7 | Opcode that goes with the start pulse |
| go_dma_o | output | 1 | DMA-mode bit that goes with the start pulse |
| eng_ld | input | 1 | Engine load strobe for status, interrupt and sequence |
| eng_status | input | 8 | Engine status value; bits [6:0] are used |
| eng_intr | input | 8 | Engine interrupt value |
| eng_seq | input | 8 | Engine sequence-step value |
| eng_raise | input | 1 | Engine request to raise the interrupt |
| illegal_o | output | 1 | Sticky flag for an unrecognised command |

## Verification
Two functions can fall in the same cycle: the host read of the interrupt register, which clears state and drops the line, and an engine load with a raise strobe. The bench provokes this by asserting the offset-5 read, `eng_ld` and `eng_raise` in one cycle. It then checks three things. The read returns the value held before the cycle. The loaded interrupt, status and sequence values all survive. The line stays high.

// File: rtl/scsi_rf_pkg.sv
package scsi_rf_pkg;

    localparam int RF_AW   = 4;
    localparam int RF_DW   = 8;
    localparam int RF_NREG = 1 << RF_AW;
    localparam int OP_W    = RF_DW - 1;

    typedef logic [RF_DW-1:0]                 byte_t;
    typedef logic [RF_NREG-1:0][RF_DW-1:0]    bank_t;

    // offsets whose meaning the block depends on
    localparam logic [RF_AW-1:0] OFS_CNT_LO  = 4'd0;
    localparam logic [RF_AW-1:0] OFS_CNT_MID = 4'd1;
    localparam logic [RF_AW-1:0] OFS_CMD     = 4'd3;
    localparam logic [RF_AW-1:0] OFS_STAT    = 4'd4;
    localparam logic [RF_AW-1:0] OFS_INTR    = 4'd5;
    localparam logic [RF_AW-1:0] OFS_SEQ     = 4'd6;
    localparam logic [RF_AW-1:0] OFS_FLAGS   = 4'd7;
    localparam logic [RF_AW-1:0] OFS_CFG1    = 4'd8;
    localparam logic [RF_AW-1:0] OFS_CFG_HI  = 4'd11;
    localparam logic [RF_AW-1:0] OFS_CHIPID  = 4'd14;

    localparam int    ST_TC_BIT    = 4;
    localparam int    ST_PEND_BIT  = 7;
    localparam byte_t ST_TC_ONLY   = 8'h10;
    localparam byte_t INT_FUNC_DONE = 8'h08;
    localparam byte_t INT_DISCONN  = 8'h20;
    localparam byte_t INT_BUS_RST  = 8'h80;
    localparam byte_t SEQ_CMD_DONE = 8'h04;
    localparam int    CFG1_QUIET_BIT = 6;

    typedef enum logic [3:0] {
        K_NOP,
        K_FLUSH,
        K_SOFT_RST,
        K_BUS_RST,
        K_MSG_ACC,
        K_PAD,
        K_EN_SEL,
        K_START,
        K_ILLEGAL
    } cmd_kind_e;

    typedef struct packed {
        bank_t               rd;
        bank_t               wr;
        logic                irq;
        logic                go;
        logic [OP_W-1:0]     go_op;
        logic                go_dma;
        logic                illegal;
    } rf_state_t;

    function automatic rf_state_t rf_reset_value(input byte_t cfg1_init, input byte_t chip_id);
        rf_state_t r;
        r = '0;
        r.rd[OFS_CFG1]   = cfg1_init;
        r.rd[OFS_CHIPID] = chip_id;
        return r;
    endfunction

endpackage

// File: rtl/scsi_rf_cmd_decode.sv
module scsi_rf_cmd_decode
    import scsi_rf_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output cmd_kind_e       kind
);
    always_comb begin
        unique case (op)
            7'h00, 7'h1a:                      kind = K_NOP;
            7'h01:                             kind = K_FLUSH;
            7'h02:                             kind = K_SOFT_RST;
            7'h03:                             kind = K_BUS_RST;
            7'h12:                             kind = K_MSG_ACC;
            7'h18:                             kind = K_PAD;
            7'h44:                             kind = K_EN_SEL;
            7'h10, 7'h11, 7'h41, 7'h42, 7'h43: kind = K_START;
            default:                           kind = K_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/scsi_rf_read_mux.sv
module scsi_rf_read_mux #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic [NREG-1:0][DW-1:0] bank,
    input  logic [AW-1:0]           addr,
    output logic [DW-1:0]           data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == AW'(i)) data = bank[i];
        end
    end
endmodule

// File: rtl/scsi_regfront.sv
module scsi_regfront
    import scsi_rf_pkg::*;
#(
    parameter logic [7:0] CFG1_INIT = 8'h07,
    parameter logic [7:0] CHIP_ID   = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [RF_AW-1:0]  bus_addr,
    input  logic [RF_DW-1:0]  bus_wdata,
    output logic [RF_DW-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              go_o,
    output logic [OP_W-1:0]   go_op_o,
    output logic              go_dma_o,
    input  logic              eng_ld,
    input  logic [RF_DW-1:0]  eng_status,
    input  logic [RF_DW-1:0]  eng_intr,
    input  logic [RF_DW-1:0]  eng_seq,
    input  logic              eng_raise,
    output logic              illegal_o
);
    localparam rf_state_t RST_STATE = rf_reset_value(CFG1_INIT, CHIP_ID);

    rf_state_t s_d, s_q;
    cmd_kind_e cmd_kind;

    // views for the bound checker
    logic [RF_DW-1:0] stat_view, intr_view, seq_view, cfg1_view;

    scsi_rf_cmd_decode u_dec (
        .op   (bus_wdata[OP_W-1:0]),
        .kind (cmd_kind)
    );

    scsi_rf_read_mux #(.NREG(RF_NREG), .DW(RF_DW)) u_rmux (
        .bank (s_q.rd),
        .addr (bus_addr),
        .data (bus_rdata)
    );

    always_comb begin
        s_d    = s_q;
        s_d.go = 1'b0;

        // host read of the interrupt register: clear-on-read side effects
        if (bus_rd && bus_addr == OFS_INTR) begin
            s_d.rd[OFS_INTR]             = '0;
            s_d.rd[OFS_STAT][ST_TC_BIT]  = 1'b0;
            s_d.rd[OFS_SEQ]              = SEQ_CMD_DONE;
            s_d.rd[OFS_STAT][ST_PEND_BIT] = 1'b0;
            s_d.irq                      = 1'b0;
        end

        if (bus_wr) begin
            if (bus_addr == OFS_CNT_LO || bus_addr == OFS_CNT_MID) begin
                s_d.wr[bus_addr]            = bus_wdata;
                s_d.rd[OFS_STAT][ST_TC_BIT] = 1'b0;
            end else if (bus_addr == OFS_CMD) begin
                if (cmd_kind == K_ILLEGAL) begin
                    s_d.illegal = 1'b1;
                end else begin
                    s_d.wr[OFS_CMD] = bus_wdata;
                    s_d.rd[OFS_CMD] = bus_wdata;
                    if (bus_wdata[RF_DW-1]) begin
                        s_d.rd[OFS_CNT_LO]  = s_q.wr[OFS_CNT_LO];
                        s_d.rd[OFS_CNT_MID] = s_q.wr[OFS_CNT_MID];
                    end
                    unique case (cmd_kind)
                        K_FLUSH: begin
                            s_d.rd[OFS_INTR]  = INT_FUNC_DONE;
                            s_d.rd[OFS_SEQ]   = '0;
                            s_d.rd[OFS_FLAGS] = '0;
                        end
                        K_SOFT_RST: begin
                            s_d = RST_STATE;
                        end
                        K_BUS_RST: begin
                            s_d.rd[OFS_INTR] = INT_BUS_RST;
                            if (!s_q.wr[OFS_CFG1][CFG1_QUIET_BIT]) begin
                                s_d.rd[OFS_STAT][ST_PEND_BIT] = 1'b1;
                                s_d.irq                       = 1'b1;
                            end
                        end
                        K_MSG_ACC: begin
                            s_d.rd[OFS_INTR]              = INT_DISCONN;
                            s_d.rd[OFS_SEQ]               = '0;
                            s_d.rd[OFS_FLAGS]             = '0;
                            s_d.rd[OFS_STAT][ST_PEND_BIT] = 1'b1;
                            s_d.irq                       = 1'b1;
                        end
                        K_PAD: begin
                            s_d.rd[OFS_STAT] = ST_TC_ONLY
                                | {s_d.rd[OFS_STAT][ST_PEND_BIT], {(RF_DW-1){1'b0}}};
                            s_d.rd[OFS_INTR] = INT_FUNC_DONE;
                            s_d.rd[OFS_SEQ]  = '0;
                        end
                        K_EN_SEL: begin
                            s_d.rd[OFS_INTR] = '0;
                        end
                        K_START: begin
                            s_d.go     = 1'b1;
                            s_d.go_op  = bus_wdata[OP_W-1:0];
                            s_d.go_dma = bus_wdata[RF_DW-1];
                        end
                        default: ;
                    endcase
                end
            end else if (bus_addr == OFS_CFG1 || bus_addr >= OFS_CFG_HI) begin
                s_d.wr[bus_addr] = bus_wdata;
                s_d.rd[bus_addr] = bus_wdata;
            end else begin
                s_d.wr[bus_addr] = bus_wdata;
            end
        end

        // phase engine write-back wins over host side effects
        if (eng_ld) begin
            s_d.rd[OFS_STAT] = {s_d.rd[OFS_STAT][ST_PEND_BIT], eng_status[RF_DW-2:0]};
            s_d.rd[OFS_INTR] = eng_intr;
            s_d.rd[OFS_SEQ]  = eng_seq;
        end
        if (eng_raise) begin
            s_d.rd[OFS_STAT][ST_PEND_BIT] = 1'b1;
            s_d.irq                       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RST_STATE;
        else        s_q <= s_d;
    end

    assign irq_o     = s_q.irq;
    assign go_o      = s_q.go;
    assign go_op_o   = s_q.go_op;
    assign go_dma_o  = s_q.go_dma;
    assign illegal_o = s_q.illegal;

    assign stat_view = s_q.rd[OFS_STAT];
    assign intr_view = s_q.rd[OFS_INTR];
    assign seq_view  = s_q.rd[OFS_SEQ];
    assign cfg1_view = s_q.rd[OFS_CFG1];

endmodule

// File: rtl/scsi_regfront_chk.sv
module scsi_regfront_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       eng_ld,
    input logic       eng_raise,
    input logic       irq_o,
    input logic       go_o,
    input logic       illegal_o,
    input logic [7:0] stat_view,
    input logic [7:0] intr_view,
    input logic [7:0] seq_view,
    input logic [7:0] cfg1_view
);
    p_irq_pending_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == stat_view[7]);

    p_intr_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'd5 && !bus_wr && !eng_ld && !eng_raise)
        |=> (intr_view == 8'h00 && seq_view == 8'h04 && !irq_o && !stat_view[4]));

    p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd3 && bus_wdata[6:0] == 7'h02 && !eng_ld && !eng_raise)
        |=> (!irq_o && !illegal_o && cfg1_view == 8'h07));

    p_go_after_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> $past(bus_wr && bus_addr == 4'd3));

    p_illegal_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && !(bus_wr && bus_addr == 4'd3)) |=> illegal_o);

    p_engine_raise_r13: assert property (@(posedge clk) disable iff (!rst_n)
        eng_raise |=> irq_o);
endmodule

bind scsi_regfront scsi_regfront_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .eng_ld    (eng_ld),
    .eng_raise (eng_raise),
    .irq_o     (irq_o),
    .go_o      (go_o),
    .illegal_o (illegal_o),
    .stat_view (stat_view),
    .intr_view (intr_view),
    .seq_view  (seq_view),
    .cfg1_view (cfg1_view)
);

// File: tb/scsi_regfront_bench.sv
module scsi_regfront_bench;
    localparam int PERIOD = 10;
    localparam int NV     = 12;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] cfg;
        logic [7:0] st;
        logic [7:0] it;
        logic [7:0] sq;
        logic       irq;
        logic       go;
        logic       ill;
    } vec_t;

    // every vector starts from: soft reset, cfg1 write, engine preload
    // status 0x13, interrupt 0x55, sequence 0x03
    localparam vec_t VEC [NV] = '{
        '{8'h01, 8'h00, 8'h13, 8'h08, 8'h00, 1'b0, 1'b0, 1'b0},  // R4 flush
        '{8'h18, 8'h00, 8'h10, 8'h08, 8'h00, 1'b0, 1'b0, 1'b0},  // R5 pad
        '{8'h03, 8'h00, 8'h93, 8'h80, 8'h03, 1'b1, 1'b0, 1'b0},  // R6 bus reset reported
        '{8'h03, 8'h40, 8'h13, 8'h80, 8'h03, 1'b0, 1'b0, 1'b0},  // R6 bus reset quiet
        '{8'h12, 8'h00, 8'h93, 8'h20, 8'h00, 1'b1, 1'b0, 1'b0},  // R7 message accept
        '{8'h44, 8'h00, 8'h13, 8'h00, 8'h03, 1'b0, 1'b0, 1'b0},  // R7 enable selection
        '{8'h00, 8'h00, 8'h13, 8'h55, 8'h03, 1'b0, 1'b0, 1'b0},  // R7 no-op
        '{8'h10, 8'h00, 8'h13, 8'h55, 8'h03, 1'b0, 1'b1, 1'b0},  // R9 transfer start
        '{8'h91, 8'h00, 8'h13, 8'h55, 8'h03, 1'b0, 1'b1, 1'b0},  // R9 DMA start
        '{8'h43, 8'h00, 8'h13, 8'h55, 8'h03, 1'b0, 1'b1, 1'b0},  // R9 select start
        '{8'h7f, 8'h00, 8'h13, 8'h55, 8'h03, 1'b0, 1'b0, 1'b1},  // R11 illegal
        '{8'h1a, 8'h00, 8'h13, 8'h55, 8'h03, 1'b0, 1'b0, 1'b0}   // R7 accepted no-op
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       irq_o, go_o, go_dma_o, illegal_o;
    logic [6:0] go_op_o;
    logic       eng_ld = 1'b0, eng_raise = 1'b0;
    logic [7:0] eng_status = '0, eng_intr = '0, eng_seq = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    scsi_regfront u_scsi_regfront (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .go_o(go_o), .go_op_o(go_op_o), .go_dma_o(go_dma_o),
        .eng_ld(eng_ld), .eng_status(eng_status), .eng_intr(eng_intr),
        .eng_seq(eng_seq), .eng_raise(eng_raise), .illegal_o(illegal_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [3:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #(PERIOD/4);
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic eng_load(input logic [7:0] st, input logic [7:0] it,
                            input logic [7:0] sq, input logic rs);
        eng_ld = 1'b1; eng_status = st; eng_intr = it; eng_seq = sq; eng_raise = rs;
        @(negedge clk);
        eng_ld = 1'b0; eng_raise = 1'b0;
    endtask

    task automatic eng_raise_only();
        eng_raise = 1'b1;
        @(negedge clk);
        eng_raise = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        host_rd(4'd4, r);  chk("R1 status", r, 8'h00);
        host_rd(4'd6, r);  chk("R1 sequence", r, 8'h00);
        host_rd(4'd8, r);  chk("R1 cfg1", r, 8'h07);
        host_rd(4'd14, r); chk("R1 chip id", r, 8'h04);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
        chk("R1 go", {7'd0, go_o}, 8'h00);
        chk("R1 illegal", {7'd0, illegal_o}, 8'h00);

        // table walk over opcodes
        for (int i = 0; i < NV; i++) begin
            host_wr(4'd3, 8'h02);
            host_wr(4'd8, VEC[i].cfg);
            eng_load(8'h13, 8'h55, 8'h03, 1'b0);
            host_wr(4'd3, VEC[i].op);
            chk($sformatf("vec%0d op %02h go", i, VEC[i].op), {7'd0, go_o}, {7'd0, VEC[i].go});
            if (VEC[i].go) begin
                chk($sformatf("vec%0d R9 go_op", i), {1'b0, go_op_o}, {1'b0, VEC[i].op[6:0]});
                chk($sformatf("vec%0d R9 go_dma", i), {7'd0, go_dma_o}, {7'd0, VEC[i].op[7]});
            end
            host_rd(4'd4, r); chk($sformatf("vec%0d op %02h status", i, VEC[i].op), r, VEC[i].st);
            chk($sformatf("vec%0d R9 go width", i), {7'd0, go_o}, 8'h00);
            host_rd(4'd6, r); chk($sformatf("vec%0d op %02h seq", i, VEC[i].op), r, VEC[i].sq);
            host_rd(4'd7, r); chk($sformatf("vec%0d R4 flags", i), r, 8'h00);
            chk($sformatf("vec%0d R2 irq", i), {7'd0, irq_o}, {7'd0, VEC[i].irq});
            chk($sformatf("vec%0d R11 illegal", i), {7'd0, illegal_o}, {7'd0, VEC[i].ill});
            host_rd(4'd5, r); chk($sformatf("vec%0d op %02h intr", i, VEC[i].op), r, VEC[i].it);
        end

        // R3 clear on read, with R13 engine raise
        host_wr(4'd3, 8'h02);
        eng_load(8'h11, 8'h18, 8'h02, 1'b1);
        chk("R13 irq after raise", {7'd0, irq_o}, 8'h01);
        host_rd(4'd4, r); chk("R2 status pending", r, 8'h91);
        eng_raise_only();
        host_rd(4'd4, r); chk("R2 double raise", r, 8'h91);
        host_rd(4'd5, r); chk("R3 old intr", r, 8'h18);
        chk("R3 irq dropped", {7'd0, irq_o}, 8'h00);
        host_rd(4'd4, r); chk("R3 status tc cleared", r, 8'h01);
        host_rd(4'd6, r); chk("R3 sequence 4", r, 8'h04);
        host_rd(4'd5, r); chk("R3 intr cleared", r, 8'h00);

        // R10 count reload and terminal count clearing
        host_wr(4'd3, 8'h02);
        eng_load(8'h10, 8'h00, 8'h00, 1'b0);
        host_wr(4'd0, 8'h34);
        host_rd(4'd4, r); chk("R10 tc cleared by count write", r, 8'h00);
        host_wr(4'd1, 8'h12);
        host_rd(4'd0, r); chk("R10 no reload yet", r, 8'h00);
        host_wr(4'd3, 8'h00);
        host_rd(4'd0, r); chk("R10 non-dma no reload", r, 8'h00);
        host_wr(4'd3, 8'h80);
        host_rd(4'd0, r); chk("R10 reload lo", r, 8'h34);
        host_rd(4'd1, r); chk("R10 reload mid", r, 8'h12);

        // R13 collision: interrupt read with engine load and raise
        host_wr(4'd3, 8'h02);
        eng_load(8'h00, 8'h08, 8'h00, 1'b1);
        bus_rd = 1'b1; bus_addr = 4'd5;
        eng_ld = 1'b1; eng_status = 8'h12; eng_intr = 8'h18; eng_seq = 8'h02; eng_raise = 1'b1;
        #(PERIOD/4);
        r = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; eng_ld = 1'b0; eng_raise = 1'b0;
        chk("R13 collision old intr", r, 8'h08);
        chk("R13 collision irq held", {7'd0, irq_o}, 8'h01);
        host_rd(4'd4, r); chk("R13 collision status", r, 8'h92);
        host_rd(4'd6, r); chk("R13 collision seq", r, 8'h02);
        host_rd(4'd5, r); chk("R13 collision intr", r, 8'h18);

        // R12 shared and write-only offsets
        host_wr(4'd3, 8'h02);
        host_wr(4'd2, 8'h77);
        host_wr(4'd4, 8'hAA);
        host_wr(4'd5, 8'hBB);
        host_wr(4'd6, 8'hCC);
        host_wr(4'd7, 8'hDD);
        host_wr(4'd9, 8'hEE);
        host_wr(4'd10, 8'h66);
        host_rd(4'd2, r);  chk("R12 offset 2", r, 8'h00);
        host_rd(4'd4, r);  chk("R12 offset 4", r, 8'h00);
        host_rd(4'd6, r);  chk("R12 offset 6", r, 8'h00);
        host_rd(4'd7, r);  chk("R12 offset 7", r, 8'h00);
        host_rd(4'd9, r);  chk("R12 offset 9", r, 8'h00);
        host_rd(4'd10, r); chk("R12 offset 10", r, 8'h00);
        host_rd(4'd5, r);  chk("R12 offset 5", r, 8'h00);
        host_wr(4'd11, 8'h5A);
        host_rd(4'd11, r); chk("R12 offset 11", r, 8'h5A);
        host_wr(4'd14, 8'h99);
        host_rd(4'd14, r); chk("R12 offset 14", r, 8'h99);

        // R11 command register not updated; R8 software reset
        host_wr(4'd3, 8'h01);
        host_wr(4'd3, 8'h65);
        host_rd(4'd3, r); chk("R11 cmd kept", r, 8'h01);
        chk("R11 illegal set", {7'd0, illegal_o}, 8'h01);
        host_wr(4'd3, 8'h44);
        chk("R11 illegal sticky", {7'd0, illegal_o}, 8'h01);
        eng_raise_only();
        host_wr(4'd8, 8'h40);
        host_wr(4'd3, 8'h02);
        chk("R8 irq low", {7'd0, irq_o}, 8'h00);
        chk("R8 illegal cleared", {7'd0, illegal_o}, 8'h00);
        host_rd(4'd8, r);  chk("R8 cfg1", r, 8'h07);
        host_rd(4'd14, r); chk("R8 chip id", r, 8'h04);
        host_rd(4'd3, r);  chk("R8 cmd cleared", r, 8'h00);
        host_wr(4'd3, 8'h03);
        chk("R6 quiet bit cleared by reset", {7'd0, irq_o}, 8'h01);

        // R9 pulse width
        host_wr(4'd3, 8'h42);
        chk("R9 pulse high", {7'd0, go_o}, 8'h01);
        chk("R9 pulse op", {1'b0, go_op_o}, 8'h42);
        @(negedge clk);
        chk("R9 pulse low", {7'd0, go_o}, 8'h00);

        summary();
        $finish;
    end
endmodule